// File: doc/BRIEF.md
# Audio Sample Rate Detector

This block works out the sample rate of a recovered digital audio stream and reports it as a 4-bit rate code with a valid flag. It has two ways of doing this.

In measuring mode, the block runs on a local reference clock. A 2-bit select tells it which of three nominal reference frequencies that clock has. The block counts reference cycles across a fixed number of frame strobes. It then compares the count with thresholds computed at elaboration. These thresholds sit midway between the nominal counts of neighbouring supported rates, so each measurement snaps to the nearest supported rate.

In channel-status mode, the reference is not used. The code is taken from channel-status bits that another block has already captured, in either consumer or professional layout. Clock recovery, biphase decoding and channel-status capture are done by other blocks.

Top module: `rate_detect`

## Requirements
- R1: `ref_sel_i` gives the reference frequency: 2'b00 = 11.2896 MHz, 2'b01 = 12.288 MHz, 2'b10 = 24.576 MHz. 2'b11 selects channel-status mode.
- R2: In measuring mode, codes are 4'b0011 = 32 kHz, 4'b0000 = 44.1 kHz, 4'b0010 = 48 kHz, 4'b1000 = 88.2 kHz, 4'b1010 = 96 kHz, 4'b1100 = 176.4 kHz and 4'b1110 = 192 kHz.
- R3: A frame rate within ±3% of a supported rate is reported as that rate.
- R4: A frame rate between two supported rates is reported as the rate whose nominal window count is nearer to the measured count.
- R5: A window count below the count for 1.25 × 192 kHz, or at or above the count for 0.75 × 32 kHz, is reported as 4'b0001. No supported rate uses this code.
- R6: If no strobe edge arrives within the reference-cycle count of `WIN_FRAMES` frames at 16 kHz, the block reports 4'b0001 with the valid flag high.
- R7: In channel-status mode with `cs_pro_i` = 0 (consumer), the code equals `cs_byte3_i[3:0]`.
- R8: In channel-status mode with `cs_pro_i` = 1 (professional), the pair {`cs_byte0_i[7:6]`, `cs_byte4_i[6:3]`} decodes as follows:
  - 01,0000 → 44.1 kHz
  - 10,0000 → 48 kHz
  - 11,0000 → 32 kHz
  - 00,1010 → 88.2 kHz
  - 00,0010 → 96 kHz
  - 00,1011 → 176.4 kHz
  - 00,0011 → 192 kHz
  - any other pair → 4'b0001
- R9: In measuring mode, the code and the valid flag change only when a window of `WIN_FRAMES` strobe periods ends or a timeout occurs.
- R10: While reset is held and after it is released, the code is 4'b0001 and the valid flag is low. The valid flag stays low until the first window or timeout completes.
- R11: A change of `ref_sel_i` clears the valid flag on the next clock edge and restarts the measurement.
- R12: In channel-status mode the window counter stays idle: no window and no timeout occur. The code follows the channel-status inputs one cycle later, with the valid flag high.
- R13: The frame strobe passes through a two-flop synchronizer. Only its rising edges mark frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Frame-rate strobe from the recovered clock domain |
| ref_sel_i | input | 2 | Reference frequency select, or 2'b11 for channel-status mode |
| cs_pro_i | input | 1 | Channel-status layout: 0 consumer, 1 professional |
| cs_byte0_i | input | 8 | Channel-status byte 0 |
| cs_byte3_i | input | 8 | Channel-status byte 3 |
| cs_byte4_i | input | 8 | Channel-status byte 4 |
| rate_code_o | output | 4 | Sample rate code |
| rate_valid_o | output | 1 | Rate code is valid |

## Verification
The assertions check on every cycle that:
- a select change clears the valid flag;
- in measuring mode the code holds between window ends;
- the valid flag rises only after a window end;
- no window ends while in channel-status mode;
- in channel-status mode the consumer code copies its nibble;
- a valid measured code is always one of the eight legal values.

The snapping of real strobe periods to rates, the ±3% tolerance, the nearest-rate choice between rates, both out-of-range limits and the 16 kHz timeout depend on long strobe trains. Only the bench's scenarios can show these, by driving chosen periods under each reference select. The same holds for the professional decode table.

// File: rtl/rate_detect_pkg.sv
package rate_detect_pkg;

  typedef logic [3:0] rate_code_t;

  localparam rate_code_t RC_44K1  = 4'b0000;
  localparam rate_code_t RC_OOR   = 4'b0001;
  localparam rate_code_t RC_48K   = 4'b0010;
  localparam rate_code_t RC_32K   = 4'b0011;
  localparam rate_code_t RC_88K2  = 4'b1000;
  localparam rate_code_t RC_96K   = 4'b1010;
  localparam rate_code_t RC_176K4 = 4'b1100;
  localparam rate_code_t RC_192K  = 4'b1110;

  localparam logic [1:0] SEL_CS = 2'b11;
  localparam int NUM_REF = 3;

  localparam longint HZ_32K   = 32000;
  localparam longint HZ_44K1  = 44100;
  localparam longint HZ_48K   = 48000;
  localparam longint HZ_88K2  = 88200;
  localparam longint HZ_96K   = 96000;
  localparam longint HZ_176K4 = 176400;
  localparam longint HZ_192K  = 192000;

  // Reference cycles expected over a window of frames at a given rate
  function automatic longint nominal_count(longint ref_hz, longint frames, longint rate_hz);
    return (ref_hz * frames) / rate_hz;
  endfunction

  // Decision point halfway between two nominal counts
  function automatic longint mid_count(longint ref_hz, longint frames,
                                       longint rate_a, longint rate_b);
    return (nominal_count(ref_hz, frames, rate_a) +
            nominal_count(ref_hz, frames, rate_b)) / 2;
  endfunction

endpackage

// File: rtl/rd_strobe_sync.sv
module rd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rd_window_ctr.sv
module rd_window_ctr #(
  parameter int WIN_FRAMES = 64,
  parameter int CNT_W      = 18,
  localparam int FRM_W     = (WIN_FRAMES > 1) ? $clog2(WIN_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] tout_i,
  output logic             done_o,
  output logic             timed_out_o,
  output logic [CNT_W-1:0] count_o
);
  typedef enum logic {ST_WAIT, ST_RUN} win_state_t;

  win_state_t       state_q;
  logic [CNT_W-1:0] cyc_q;
  logic [FRM_W-1:0] frm_q;
  logic [CNT_W-1:0] cyc_inc;
  logic             last_frame;

  assign cyc_inc    = cyc_q + CNT_W'(1);
  assign last_frame = (frm_q == FRM_W'(WIN_FRAMES - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i || !enable_i) begin
      state_q     <= ST_WAIT;
      cyc_q       <= '0;
      frm_q       <= '0;
      done_o      <= 1'b0;
      timed_out_o <= 1'b0;
      count_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (edge_i) begin
        if (state_q == ST_WAIT) begin
          state_q <= ST_RUN;
          cyc_q   <= '0;
          frm_q   <= '0;
        end else if (last_frame) begin
          done_o      <= 1'b1;
          timed_out_o <= 1'b0;
          count_o     <= cyc_inc;
          cyc_q       <= '0;
          frm_q       <= '0;
        end else begin
          frm_q <= frm_q + FRM_W'(1);
          cyc_q <= cyc_inc;
        end
      end else if (cyc_inc >= tout_i) begin
        done_o      <= 1'b1;
        timed_out_o <= 1'b1;
        state_q     <= ST_WAIT;
        cyc_q       <= '0;
        frm_q       <= '0;
      end else begin
        cyc_q <= cyc_inc;
      end
    end
  end
endmodule

// File: rtl/rd_classify.sv
module rd_classify
  import rate_detect_pkg::*;
#(
  parameter int unsigned REF0_HZ    = 11289600,
  parameter int unsigned REF1_HZ    = 12288000,
  parameter int unsigned REF2_HZ    = 24576000,
  parameter int unsigned WIN_FRAMES = 64,
  parameter int unsigned TIMEOUT_HZ = 16000,
  parameter int unsigned LOW_HZ     = 24000,
  parameter int unsigned HIGH_HZ    = 240000,
  parameter int          CNT_W      = 18
) (
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output rate_code_t       code_o,
  output logic [CNT_W-1:0] tout_o
);
  rate_code_t       code_r [NUM_REF];
  logic [CNT_W-1:0] tout_r [NUM_REF];

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    localparam longint F = (g == 0) ? longint'(REF0_HZ) :
                           (g == 1) ? longint'(REF1_HZ) : longint'(REF2_HZ);
    localparam longint W = longint'(WIN_FRAMES);
    // thresholds in ascending count order (descending rate)
    localparam logic [CNT_W-1:0] B_HI  = CNT_W'(nominal_count(F, W, longint'(HIGH_HZ)));
    localparam logic [CNT_W-1:0] B_192 = CNT_W'(mid_count(F, W, HZ_192K, HZ_176K4));
    localparam logic [CNT_W-1:0] B_176 = CNT_W'(mid_count(F, W, HZ_176K4, HZ_96K));
    localparam logic [CNT_W-1:0] B_96  = CNT_W'(mid_count(F, W, HZ_96K, HZ_88K2));
    localparam logic [CNT_W-1:0] B_88  = CNT_W'(mid_count(F, W, HZ_88K2, HZ_48K));
    localparam logic [CNT_W-1:0] B_48  = CNT_W'(mid_count(F, W, HZ_48K, HZ_44K1));
    localparam logic [CNT_W-1:0] B_44  = CNT_W'(mid_count(F, W, HZ_44K1, HZ_32K));
    localparam logic [CNT_W-1:0] B_LO  = CNT_W'(nominal_count(F, W, longint'(LOW_HZ)));
    localparam logic [CNT_W-1:0] T_OUT = CNT_W'(nominal_count(F, W, longint'(TIMEOUT_HZ)));

    always_comb begin
      if      (count_i <  B_HI)  code_r[g] = RC_OOR;
      else if (count_i <  B_192) code_r[g] = RC_192K;
      else if (count_i <  B_176) code_r[g] = RC_176K4;
      else if (count_i <  B_96)  code_r[g] = RC_96K;
      else if (count_i <  B_88)  code_r[g] = RC_88K2;
      else if (count_i <  B_48)  code_r[g] = RC_48K;
      else if (count_i <  B_44)  code_r[g] = RC_44K1;
      else if (count_i <  B_LO)  code_r[g] = RC_32K;
      else                       code_r[g] = RC_OOR;
    end

    assign tout_r[g] = T_OUT;
  end

  always_comb begin
    case (sel_i)
      2'b00:   begin code_o = code_r[0]; tout_o = tout_r[0]; end
      2'b01:   begin code_o = code_r[1]; tout_o = tout_r[1]; end
      2'b10:   begin code_o = code_r[2]; tout_o = tout_r[2]; end
      default: begin code_o = RC_OOR;    tout_o = tout_r[0]; end
    endcase
  end
endmodule

// File: rtl/rd_cs_decode.sv
module rd_cs_decode
  import rate_detect_pkg::*;
(
  input  logic       pro_i,
  input  logic [7:0] byte0_i,
  input  logic [7:0] byte3_i,
  input  logic [7:0] byte4_i,
  output rate_code_t code_o
);
  logic [1:0] base_fld;
  logic [3:0] ext_fld;
  rate_code_t pro_code;
  logic       unused_bits;

  assign base_fld    = byte0_i[7:6];
  assign ext_fld     = byte4_i[6:3];
  assign unused_bits = ^{byte0_i[5:0], byte3_i[7:4], byte4_i[7], byte4_i[2:0]};

  always_comb begin
    case ({base_fld, ext_fld})
      6'b01_0000: pro_code = RC_44K1;
      6'b10_0000: pro_code = RC_48K;
      6'b11_0000: pro_code = RC_32K;
      6'b00_1010: pro_code = RC_88K2;
      6'b00_0010: pro_code = RC_96K;
      6'b00_1011: pro_code = RC_176K4;
      6'b00_0011: pro_code = RC_192K;
      default:    pro_code = RC_OOR;
    endcase
  end

  assign code_o = pro_i ? pro_code : rate_code_t'(byte3_i[3:0]);
endmodule

// File: rtl/rate_detect.sv
module rate_detect
  import rate_detect_pkg::*;
#(
  parameter int unsigned REF0_HZ    = 11289600,
  parameter int unsigned REF1_HZ    = 12288000,
  parameter int unsigned REF2_HZ    = 24576000,
  parameter int unsigned WIN_FRAMES = 64,
  parameter int unsigned TIMEOUT_HZ = 16000,
  parameter int unsigned LOW_HZ     = 24000,
  parameter int unsigned HIGH_HZ    = 240000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       strobe_i,
  input  logic [1:0] ref_sel_i,
  input  logic       cs_pro_i,
  input  logic [7:0] cs_byte0_i,
  input  logic [7:0] cs_byte3_i,
  input  logic [7:0] cs_byte4_i,
  output logic [3:0] rate_code_o,
  output logic       rate_valid_o
);
  localparam longint MAX_REF = (REF0_HZ > REF1_HZ) ?
                               ((REF0_HZ > REF2_HZ) ? longint'(REF0_HZ) : longint'(REF2_HZ)) :
                               ((REF1_HZ > REF2_HZ) ? longint'(REF1_HZ) : longint'(REF2_HZ));
  localparam longint MAX_TOUT = nominal_count(MAX_REF, longint'(WIN_FRAMES), longint'(TIMEOUT_HZ));
  localparam int     CNT_W    = $clog2(MAX_TOUT + 1) + 1;

  logic [1:0]       sel_q;
  logic             sel_change;
  logic             cs_mode;
  logic             frame_rise;
  logic             meas_done;
  logic             meas_tout;
  logic [CNT_W-1:0] meas_count;
  logic [CNT_W-1:0] tout_lim;
  rate_code_t       meas_code;
  rate_code_t       cs_code;

  assign sel_change = (ref_sel_i != sel_q);
  assign cs_mode    = (ref_sel_i == SEL_CS);

  rd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .rise_o   (frame_rise)
  );

  rd_window_ctr #(.WIN_FRAMES(WIN_FRAMES), .CNT_W(CNT_W)) u_win (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .restart_i   (sel_change),
    .enable_i    (!cs_mode),
    .edge_i      (frame_rise),
    .tout_i      (tout_lim),
    .done_o      (meas_done),
    .timed_out_o (meas_tout),
    .count_o     (meas_count)
  );

  rd_classify #(
    .REF0_HZ(REF0_HZ), .REF1_HZ(REF1_HZ), .REF2_HZ(REF2_HZ),
    .WIN_FRAMES(WIN_FRAMES), .TIMEOUT_HZ(TIMEOUT_HZ),
    .LOW_HZ(LOW_HZ), .HIGH_HZ(HIGH_HZ), .CNT_W(CNT_W)
  ) u_cls (
    .sel_i   (ref_sel_i),
    .count_i (meas_count),
    .code_o  (meas_code),
    .tout_o  (tout_lim)
  );

  rd_cs_decode u_cs (
    .pro_i   (cs_pro_i),
    .byte0_i (cs_byte0_i),
    .byte3_i (cs_byte3_i),
    .byte4_i (cs_byte4_i),
    .code_o  (cs_code)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q        <= ref_sel_i;
      rate_code_o  <= RC_OOR;
      rate_valid_o <= 1'b0;
    end else begin
      sel_q <= ref_sel_i;
      if (sel_change) begin
        rate_valid_o <= 1'b0;
      end else if (cs_mode) begin
        rate_code_o  <= cs_code;
        rate_valid_o <= 1'b1;
      end else if (meas_done) begin
        rate_code_o  <= meas_tout ? RC_OOR : meas_code;
        rate_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rate_detect_chk.sv
module rate_detect_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic [1:0] ref_sel_i,
  input logic       cs_pro_i,
  input logic [7:0] cs_byte3_i,
  input logic [3:0] rate_code_o,
  input logic       rate_valid_o,
  input logic       meas_done
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)               age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_SEL_CLEARS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q != 2'd0 && ref_sel_i != $past(ref_sel_i)) |=> !rate_valid_o); // R11

  AST_CODE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (ref_sel_i != 2'b11 && !meas_done) |=> $stable(rate_code_o)); // R9

  AST_VALID_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 2'd2 && $rose(rate_valid_o) && $past(ref_sel_i) != 2'b11) |-> $past(meas_done)); // R10

  AST_CS_NO_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 2'd2 && ref_sel_i == 2'b11 && $past(ref_sel_i) == 2'b11) |-> !meas_done); // R12

  AST_CONSUMER_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q == 2'd3 && ref_sel_i == 2'b11 && $past(ref_sel_i) == 2'b11 &&
     $past(ref_sel_i, 2) == 2'b11 && !$past(cs_pro_i))
    |-> rate_code_o == $past(cs_byte3_i[3:0])); // R7

  AST_LEGAL_MEASURED_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 2'd2 && rate_valid_o && ref_sel_i != 2'b11 && $past(ref_sel_i) != 2'b11)
    |-> (rate_code_o inside {4'b0000, 4'b0001, 4'b0010, 4'b0011,
                             4'b1000, 4'b1010, 4'b1100, 4'b1110})); // R2
endmodule

bind rate_detect rate_detect_chk u_rate_detect_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .ref_sel_i    (ref_sel_i),
  .cs_pro_i     (cs_pro_i),
  .cs_byte3_i   (cs_byte3_i),
  .rate_code_o  (rate_code_o),
  .rate_valid_o (rate_valid_o),
  .meas_done    (meas_done)
);

// File: tb/rate_detect_bench.sv
`timescale 1ns/1ps
module rate_detect_bench;
  localparam int WIN = 8;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] per;
    logic [3:0]  code;
    logic [1:0]  kind; // 0:R2 1:R3 2:R4 3:R5
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'd256, 4'b0000, 2'd0}, // 44.1k @ ref0
    '{2'd1, 16'd256, 4'b0010, 2'd0}, // 48k @ ref1
    '{2'd0, 16'd235, 4'b0010, 2'd0}, // 48k @ ref0
    '{2'd2, 16'd768, 4'b0011, 2'd0}, // 32k @ ref2
    '{2'd0, 16'd353, 4'b0011, 2'd0}, // 32k @ ref0
    '{2'd1, 16'd128, 4'b1010, 2'd0}, // 96k @ ref1
    '{2'd0, 16'd128, 4'b1000, 2'd0}, // 88.2k @ ref0
    '{2'd0, 16'd118, 4'b1010, 2'd0}, // 96k @ ref0
    '{2'd2, 16'd139, 4'b1100, 2'd0}, // 176.4k @ ref2
    '{2'd0, 16'd64,  4'b1100, 2'd0}, // 176.4k @ ref0
    '{2'd1, 16'd64,  4'b1110, 2'd0}, // 192k @ ref1
    '{2'd0, 16'd59,  4'b1110, 2'd0}, // 192k @ ref0
    '{2'd2, 16'd128, 4'b1110, 2'd0}, // 192k @ ref2
    '{2'd1, 16'd279, 4'b0000, 2'd0}, // 44.1k @ ref1
    '{2'd1, 16'd384, 4'b0011, 2'd0}, // 32k @ ref1
    '{2'd1, 16'd248, 4'b0010, 2'd1}, // 48k +3.2%
    '{2'd1, 16'd264, 4'b0010, 2'd1}, // 48k -3.0%
    '{2'd1, 16'd215, 4'b0010, 2'd2}, // 57.2k nearer 48k
    '{2'd1, 16'd180, 4'b1000, 2'd2}, // 68.3k nearer 88.2k
    '{2'd1, 16'd40,  4'b0001, 2'd3}, // 307k too fast
    '{2'd0, 16'd600, 4'b0001, 2'd3}  // 18.8k too slow, before timeout
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       strobe;
  logic [1:0] sel;
  logic       cs_pro;
  logic [7:0] cs_b0, cs_b3, cs_b4;
  logic [3:0] code;
  logic       valid;

  int n_chk = 0;
  int n_bad = 0;
  int per = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rate_detect #(.WIN_FRAMES(WIN)) u_rate_detect (
    .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .ref_sel_i(sel),
    .cs_pro_i(cs_pro), .cs_byte0_i(cs_b0), .cs_byte3_i(cs_b3), .cs_byte4_i(cs_b4),
    .rate_code_o(code), .rate_valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe generator, period in reference cycles, 0 = stopped
  initial begin
    strobe = 1'b0;
    forever begin
      if (per == 0) begin
        strobe = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = per;
        strobe = 1'b1;
        repeat (p / 2) @(negedge clk);
        strobe = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int prev;
    string tag;
    rst = 1'b1; sel = 2'd0; cs_pro = 1'b0;
    cs_b0 = 8'h00; cs_b3 = 8'h00; cs_b4 = 8'h00;
    wait_cyc(5);
    // R10 reset state
    check(code == 4'b0001, "R10", "code in reset", code, 4'b0001);
    check(valid == 1'b0, "R10", "valid in reset", {3'b0, valid}, 4'h0);
    rst = 1'b0;
    wait_cyc(3);
    check(valid == 1'b0, "R10", "valid before first window", {3'b0, valid}, 4'h0);

    // vector table: R1 select mapping, R13 strobe edges, R9 window results
    prev = 0;
    for (int i = 0; i < NV; i++) begin
      sel = VEC[i].sel;
      per = int'(VEC[i].per);
      wait_cyc(2 * WIN * per + prev + 200);
      case (VEC[i].kind)
        2'd0: tag = "R2/R1/R13";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R5";
      endcase
      check(valid == 1'b1, tag, $sformatf("valid vec %0d", i), {3'b0, valid}, 4'h1);
      check(code == VEC[i].code, tag, $sformatf("code vec %0d", i), code, VEC[i].code);
      prev = per;
    end

    // R11 select change clears valid; R9 stays low inside the first window
    sel = 2'd1; per = 256;
    wait_cyc(2);
    check(valid == 1'b0, "R11", "valid after select change", {3'b0, valid}, 4'h0);
    wait_cyc(WIN * 256 / 2);
    check(valid == 1'b0, "R9", "valid mid first window", {3'b0, valid}, 4'h0);
    check(code == 4'b0001, "R9", "code held mid window", code, 4'b0001);
    wait_cyc(2 * WIN * 256 + 600);
    check(valid == 1'b1 && code == 4'b0010, "R9", "code after window", code, 4'b0010);

    // R6 timeout with ref2: 24.576 MHz * 8 / 16 kHz = 12288 cycles
    sel = 2'd2; per = 0;
    wait_cyc(256 + 12288 + 300);
    check(valid == 1'b1, "R6", "valid on timeout", {3'b0, valid}, 4'h1);
    check(code == 4'b0001, "R6", "code on timeout", code, 4'b0001);

    // R7 consumer copy, strobes running
    per = 256;
    sel = 2'd3; cs_pro = 1'b0; cs_b3 = 8'hBA;
    wait_cyc(3);
    check(valid == 1'b1, "R12", "valid in cs mode", {3'b0, valid}, 4'h1);
    check(code == 4'b1010, "R7", "consumer nibble", code, 4'b1010);
    cs_b3 = 8'h53;
    wait_cyc(2);
    check(code == 4'b0011, "R7", "consumer nibble 2", code, 4'b0011);

    // R8 professional decode
    cs_pro = 1'b1; cs_b0 = 8'h40; cs_b4 = 8'h00;
    wait_cyc(2);
    check(code == 4'b0000, "R8", "pro 01/0000", code, 4'b0000);
    cs_b0 = 8'hC0; cs_b4 = 8'h00;
    wait_cyc(2);
    check(code == 4'b0011, "R8", "pro 11/0000", code, 4'b0011);
    cs_b0 = 8'h00; cs_b4 = 8'h58; // bits 6..3 = 1011
    wait_cyc(2);
    check(code == 4'b1100, "R8", "pro 00/1011", code, 4'b1100);
    cs_b0 = 8'h00; cs_b4 = 8'h18; // 0011
    wait_cyc(2);
    check(code == 4'b1110, "R8", "pro 00/0011", code, 4'b1110);
    cs_b0 = 8'h80; cs_b4 = 8'h08; // 10/0001 not in table
    wait_cyc(2);
    check(code == 4'b0001, "R8", "pro other", code, 4'b0001);

    // R12 no timeout in cs mode with strobes stopped
    cs_b0 = 8'h80; cs_b4 = 8'h00; // 48k
    per = 0;
    wait_cyc(13000);
    check(valid == 1'b1, "R12", "valid held, no timeout", {3'b0, valid}, 4'h1);
    check(code == 4'b0010, "R12", "code held, no timeout", code, 4'b0010);

    // R11 leaving cs mode clears valid
    sel = 2'd0;
    wait_cyc(2);
    check(valid == 1'b0, "R11", "valid after leaving cs", {3'b0, valid}, 4'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule